// File: doc/BRIEF.md
# Protected Page Metadata Table

This block keeps one metadata record for every page of a protected on-chip page cache, and it arbitrates the locks that page-add operations need. Each record holds the page's read, write and execute permissions, its page type, the linear address it maps, the index of the control page that owns it, and four state flags: valid, blocked, pending and modified. Requesters first lock the pages they work on, then commit the add, then release the locks.

A page-add locks its target page exclusively and its owning control page shared. Several adds that name the same owner can therefore run side by side. A measurement-extend or initialize operation on that owner takes the owner page exclusively, so it cannot overlap those adds. If a lock cannot be granted, the request is refused in the same cycle with a conflict indication; nothing is queued. A commit is accepted only from the requester that holds the target page exclusively. An accepted commit writes the record, sets valid and clears blocked, pending and modified. A lookup port reads any record, and its lock state, combinationally.

Top module: `page_meta_table`

## Requirements
- R1: After reset every record reads as not valid with all flags clear, and no page holds an exclusive or a shared lock.
- R2: An exclusive acquire (`lockShared`=0) on a page with no holder is granted in the same cycle. From the next cycle the lookup reports that page as exclusively held.
- R3: An exclusive acquire on a page that has an exclusive holder, or one or more shared holders, reports a conflict in the same cycle and leaves the lock state unchanged.
- R4: A shared acquire (`lockShared`=1) is granted whenever the page has no exclusive holder, so several requesters can hold one page shared. It conflicts while an exclusive holder exists.
- R5: While any shared holder remains on an owner page, an exclusive acquire on that page (the extend/initialize case) conflicts. Once the last shared holder releases, the same exclusive acquire is granted.
- R6: A commit from the requester that holds the target page exclusively writes the permissions, type, linear address and owner index, sets valid, and clears blocked, pending and modified. The lookup shows the new record from the next cycle. Permissions are packed as {R,W,X} with R in bit 2.
- R7: When the committed type is thread-control (type code 2), the stored permissions are 3'b000 whatever was requested. Type codes: regular=0, control=1, thread-control=2, shadow-stack-first=3, shadow-stack-rest=4.
- R8: A commit to a page that the committing requester does not hold exclusively leaves the record unchanged. It raises `cmtError` for exactly the cycle after the commit.
- R9: An exclusive release from the holding requester frees the page. An exclusive release from any other requester is ignored. Each shared release removes one shared holder.
- R10: During an acquire, exactly one of `lockGrant` and `lockConflict` is high. During a release, neither is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lockReq | input | 1 | Lock request strobe |
| lockRelease | input | 1 | 1 = release, 0 = acquire |
| lockShared | input | 1 | 1 = shared mode, 0 = exclusive mode |
| lockPage | input | IDX_W | Page index of the lock request |
| lockId | input | REQ_W | Requester identifier |
| lockGrant | output | 1 | Acquire granted (combinational) |
| lockConflict | output | 1 | Acquire refused (combinational) |
| cmtValid | input | 1 | Add-commit strobe |
| cmtPage | input | IDX_W | Target page of the commit |
| cmtId | input | REQ_W | Committing requester |
| cmtPerm | input | 3 | Requested {R,W,X} |
| cmtType | input | 3 | Page type code |
| cmtLinAddr | input | ADDR_W | Linear address of the page |
| cmtOwner | input | IDX_W | Index of the owning control page |
| cmtError | output | 1 | One-cycle pulse for a rejected commit |
| lkpPage | input | IDX_W | Lookup index |
| lkpValid | output | 1 | Record valid |
| lkpType | output | 3 | Stored type |
| lkpPerm | output | 3 | Stored {R,W,X} |
| lkpLinAddr | output | ADDR_W | Stored linear address |
| lkpOwner | output | IDX_W | Stored owner index |
| lkpFlags | output | 3 | {modified, pending, blocked} |
| lkpExcl | output | 1 | Page held exclusively |
| lkpShared | output | 1 | Page has at least one shared holder |

## Verification
A corrupted lock record shows up at the ports in the very next acquire or lookup for that page: either the grant/conflict pair has the wrong polarity in that cycle, or the lookup lock bits disagree with the history of acquires and releases. A wrong holder identity shows up when the holder's own commit is rejected or a stranger's release takes effect. Both can be seen within one cycle of the next commit or release. A bad record write shows up at the lookup one cycle after the commit, as a wrong field, a stray flag, or permissions left set on a thread-control page.

// File: rtl/page_meta_pkg.sv
package page_meta_pkg;

  typedef enum logic [2:0] {
    PT_REGULAR = 3'd0,
    PT_CONTROL = 3'd1,
    PT_THREAD  = 3'd2,
    PT_SSFIRST = 3'd3,
    PT_SSREST  = 3'd4
  } pageType_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic clearPerm;
  } dpStrobe_t;

endpackage

// File: rtl/page_meta_ctrl.sv
module page_meta_ctrl
  import page_meta_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int REQ_W     = 3,
  localparam int IDX_W    = $clog2(NUM_PAGES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lockReq,
  input  logic             lockRelease,
  input  logic             lockShared,
  input  logic [IDX_W-1:0] lockPage,
  input  logic [REQ_W-1:0] lockId,
  output logic             lockGrant,
  output logic             lockConflict,
  input  logic             cmtValid,
  input  logic [IDX_W-1:0] cmtPage,
  input  logic [REQ_W-1:0] cmtId,
  input  logic [2:0]       cmtType,
  output dpStrobe_t        strobe,
  output logic             cmtError,
  input  logic [IDX_W-1:0] lkpPage,
  output logic             lkpExcl,
  output logic             lkpShared
);

  localparam int CNT_W = REQ_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(2 ** REQ_W);

  logic             exclHeld  [NUM_PAGES];
  logic [REQ_W-1:0] exclOwner [NUM_PAGES];
  logic [CNT_W-1:0] shareCnt  [NUM_PAGES];

  logic             curExcl;
  logic [REQ_W-1:0] curOwner;
  logic [CNT_W-1:0] curCnt;
  logic             acquire, grantOk, relExcl, relShared, cmtOk;

  always_comb begin
    curExcl   = exclHeld[lockPage];
    curOwner  = exclOwner[lockPage];
    curCnt    = shareCnt[lockPage];
    acquire   = lockReq && !lockRelease;
    grantOk   = lockShared ? (!curExcl && (curCnt != CNT_MAX))
                           : (!curExcl && (curCnt == '0));
    lockGrant    = acquire && grantOk;
    lockConflict = acquire && !grantOk;
    relExcl   = lockReq && lockRelease && !lockShared && curExcl && (curOwner == lockId);
    relShared = lockReq && lockRelease && lockShared && (curCnt != '0);
  end

  for (genvar p = 0; p < NUM_PAGES; p++) begin : gSlot
    logic hit;
    assign hit = (lockPage == IDX_W'(p));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        exclHeld[p]  <= 1'b0;
        exclOwner[p] <= '0;
        shareCnt[p]  <= '0;
      end else if (hit) begin
        if (lockGrant && !lockShared) begin
          exclHeld[p]  <= 1'b1;
          exclOwner[p] <= lockId;
        end else if (relExcl) begin
          exclHeld[p]  <= 1'b0;
        end
        if (lockGrant && lockShared) begin
          shareCnt[p] <= shareCnt[p] + CNT_W'(1);
        end else if (relShared) begin
          shareCnt[p] <= shareCnt[p] - CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    cmtOk            = cmtValid && exclHeld[cmtPage] && (exclOwner[cmtPage] == cmtId);
    strobe.wrEn      = cmtOk;
    strobe.clearPerm = (cmtType == PT_THREAD);
    lkpExcl          = exclHeld[lkpPage];
    lkpShared        = (shareCnt[lkpPage] != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmtError <= 1'b0;
    else       cmtError <= cmtValid && !cmtOk;
  end

endmodule

// File: rtl/page_meta_data.sv
module page_meta_data
  import page_meta_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int ADDR_W    = 48,
  localparam int IDX_W    = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [2:0]        wrPerm,
  input  logic [2:0]        wrType,
  input  logic [ADDR_W-1:0] wrLinAddr,
  input  logic [IDX_W-1:0]  wrOwner,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              rdValid,
  output logic [2:0]        rdType,
  output logic [2:0]        rdPerm,
  output logic [ADDR_W-1:0] rdLinAddr,
  output logic [IDX_W-1:0]  rdOwner,
  output logic [2:0]        rdFlags
);

  logic              vld   [NUM_PAGES];
  logic [2:0]        perm  [NUM_PAGES];
  logic [2:0]        ptype [NUM_PAGES];
  logic [ADDR_W-1:0] lin   [NUM_PAGES];
  logic [IDX_W-1:0]  own   [NUM_PAGES];
  logic [2:0]        flags [NUM_PAGES];

  for (genvar p = 0; p < NUM_PAGES; p++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vld[p]   <= 1'b0;
        perm[p]  <= '0;
        ptype[p] <= '0;
        lin[p]   <= '0;
        own[p]   <= '0;
        flags[p] <= '0;
      end else if (strobe.wrEn && (wrIdx == IDX_W'(p))) begin
        vld[p]   <= 1'b1;
        flags[p] <= 3'b000;
        perm[p]  <= strobe.clearPerm ? 3'b000 : wrPerm;
        ptype[p] <= wrType;
        lin[p]   <= wrLinAddr;
        own[p]   <= wrOwner;
      end
    end
  end

  always_comb begin
    rdValid   = vld[rdIdx];
    rdType    = ptype[rdIdx];
    rdPerm    = perm[rdIdx];
    rdLinAddr = lin[rdIdx];
    rdOwner   = own[rdIdx];
    rdFlags   = flags[rdIdx];
  end

endmodule

// File: rtl/page_meta_table.sv
module page_meta_table
  import page_meta_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int REQ_W     = 3,
  parameter int ADDR_W    = 48,
  localparam int IDX_W    = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lockReq,
  input  logic              lockRelease,
  input  logic              lockShared,
  input  logic [IDX_W-1:0]  lockPage,
  input  logic [REQ_W-1:0]  lockId,
  output logic              lockGrant,
  output logic              lockConflict,
  input  logic              cmtValid,
  input  logic [IDX_W-1:0]  cmtPage,
  input  logic [REQ_W-1:0]  cmtId,
  input  logic [2:0]        cmtPerm,
  input  logic [2:0]        cmtType,
  input  logic [ADDR_W-1:0] cmtLinAddr,
  input  logic [IDX_W-1:0]  cmtOwner,
  output logic              cmtError,
  input  logic [IDX_W-1:0]  lkpPage,
  output logic              lkpValid,
  output logic [2:0]        lkpType,
  output logic [2:0]        lkpPerm,
  output logic [ADDR_W-1:0] lkpLinAddr,
  output logic [IDX_W-1:0]  lkpOwner,
  output logic [2:0]        lkpFlags,
  output logic              lkpExcl,
  output logic              lkpShared
);

  dpStrobe_t strobe;

  page_meta_ctrl #(.NUM_PAGES(NUM_PAGES), .REQ_W(REQ_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .lockReq(lockReq), .lockRelease(lockRelease), .lockShared(lockShared),
    .lockPage(lockPage), .lockId(lockId),
    .lockGrant(lockGrant), .lockConflict(lockConflict),
    .cmtValid(cmtValid), .cmtPage(cmtPage), .cmtId(cmtId), .cmtType(cmtType),
    .strobe(strobe), .cmtError(cmtError),
    .lkpPage(lkpPage), .lkpExcl(lkpExcl), .lkpShared(lkpShared)
  );

  page_meta_data #(.NUM_PAGES(NUM_PAGES), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrIdx(cmtPage), .wrPerm(cmtPerm), .wrType(cmtType),
    .wrLinAddr(cmtLinAddr), .wrOwner(cmtOwner),
    .rdIdx(lkpPage), .rdValid(lkpValid), .rdType(lkpType), .rdPerm(lkpPerm),
    .rdLinAddr(lkpLinAddr), .rdOwner(lkpOwner), .rdFlags(lkpFlags)
  );

endmodule

// File: rtl/page_meta_table_chk.sv
module page_meta_table_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             lockReq,
  input logic             lockRelease,
  input logic             lockShared,
  input logic [IDX_W-1:0] lockPage,
  input logic             lockGrant,
  input logic             lockConflict,
  input logic             cmtValid,
  input logic             cmtError,
  input logic [IDX_W-1:0] lkpPage,
  input logic             lkpValid,
  input logic [2:0]       lkpType,
  input logic [2:0]       lkpPerm,
  input logic [2:0]       lkpFlags,
  input logic             lkpExcl,
  input logic             lkpShared
);

  AST_ACQ_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rstN)
    (lockReq && !lockRelease) |-> $countones({lockGrant, lockConflict}) == 1); // R10

  AST_REL_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (lockReq && lockRelease) |-> !lockGrant && !lockConflict); // R10

  AST_EXCL_ON_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (lockGrant && !lockShared && lkpPage == lockPage) |-> !lkpExcl && !lkpShared); // R3

  AST_SHARED_NO_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (lockGrant && lockShared && lkpPage == lockPage) |-> !lkpExcl); // R4

  AST_ERR_AFTER_CMT: assert property (@(posedge clk) disable iff (!rstN)
    cmtError |-> $past(cmtValid)); // R8

  AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    lkpValid |-> lkpFlags == 3'b000); // R6

  AST_THREAD_NOPERM: assert property (@(posedge clk) disable iff (!rstN)
    (lkpValid && lkpType == 3'd2) |-> lkpPerm == 3'b000); // R7

endmodule

bind page_meta_table page_meta_table_chk #(.IDX_W(IDX_W)) uChk (.*);

// File: tb/page_meta_table_test.sv
`timescale 1ns/1ps
module page_meta_table_test;

  localparam int IDX_W = 4;
  localparam int REQ_W = 3;
  localparam int ADDR_W = 48;

  logic clk = 1'b0, rstN = 1'b0;
  logic lockReq = 0, lockRelease = 0, lockShared = 0;
  logic [IDX_W-1:0] lockPage = '0;
  logic [REQ_W-1:0] lockId = '0;
  logic lockGrant, lockConflict;
  logic cmtValid = 0;
  logic [IDX_W-1:0] cmtPage = '0, cmtOwner = '0;
  logic [REQ_W-1:0] cmtId = '0;
  logic [2:0] cmtPerm = '0, cmtType = '0;
  logic [ADDR_W-1:0] cmtLinAddr = '0;
  logic cmtError;
  logic [IDX_W-1:0] lkpPage = '0;
  logic lkpValid, lkpExcl, lkpShared;
  logic [2:0] lkpType, lkpPerm, lkpFlags;
  logic [ADDR_W-1:0] lkpLinAddr;
  logic [IDX_W-1:0] lkpOwner;

  page_meta_table uut (.*);

  always #10 clk = ~clk;

  typedef struct {
    int          due;
    int          sel;
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int cyc = 0, checks = 0, failures = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] actual(int sel);
    case (sel)
      0: return 64'(lockGrant);
      1: return 64'(lockConflict);
      2: return 64'(cmtError);
      3: return 64'(lkpValid);
      4: return 64'(lkpType);
      5: return 64'(lkpPerm);
      6: return 64'(lkpExcl);
      7: return 64'(lkpShared);
      8: return 64'(lkpLinAddr);
      9: return 64'(lkpOwner);
      default: return 64'(lkpFlags);
    endcase
  endfunction

  // monitor: compare expected items when their cycle arrives
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [63:0] act;
      it = sb.pop_front();
      act = actual(it.sel);
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic push(int due, int sel, logic [63:0] exp, string tag);
    item_t it;
    it.due = due; it.sel = sel; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic stepStart();
    @(posedge clk); #2;
    lockReq = 0; lockRelease = 0; lockShared = 0; cmtValid = 0;
  endtask

  task automatic acq(int page, bit shared, int id, bit expGrant, string tag);
    stepStart();
    lockReq = 1; lockRelease = 0; lockShared = shared;
    lockPage = IDX_W'(page); lockId = REQ_W'(id);
    push(cyc, 0, 64'(expGrant), tag);
    push(cyc, 1, 64'(!expGrant), tag);
  endtask

  task automatic rel(int page, bit shared, int id, string tag);
    stepStart();
    lockReq = 1; lockRelease = 1; lockShared = shared;
    lockPage = IDX_W'(page); lockId = REQ_W'(id);
    push(cyc, 0, 64'd0, tag);
    push(cyc, 1, 64'd0, tag);
  endtask

  task automatic commit(int page, int id, logic [2:0] perm, logic [2:0] ptype,
                        logic [ADDR_W-1:0] addr, int owner, bit expErr, string tag);
    stepStart();
    cmtValid = 1; cmtPage = IDX_W'(page); cmtId = REQ_W'(id);
    cmtPerm = perm; cmtType = ptype; cmtLinAddr = addr; cmtOwner = IDX_W'(owner);
    push(cyc + 1, 2, 64'(expErr), tag);
  endtask

  task automatic look(int page, bit expValid, bit expExcl, bit expShared,
                      logic [2:0] expType, logic [2:0] expPerm,
                      logic [ADDR_W-1:0] expAddr, int expOwner, string tag);
    stepStart();
    lkpPage = IDX_W'(page);
    push(cyc, 3, 64'(expValid), tag);
    push(cyc, 6, 64'(expExcl), tag);
    push(cyc, 7, 64'(expShared), tag);
    push(cyc, 10, 64'd0, tag);
    if (expValid) begin
      push(cyc, 4, 64'(expType), tag);
      push(cyc, 5, 64'(expPerm), tag);
      push(cyc, 8, 64'(expAddr), tag);
      push(cyc, 9, 64'(expOwner), tag);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    // R1: reset state
    look(0, 0, 0, 0, 0, 0, 0, 0, "R1");
    look(15, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R2: exclusive on free page
    acq(3, 0, 1, 1, "R2");
    look(3, 0, 1, 0, 0, 0, 0, 0, "R2");
    // R3 / R4: conflicts against exclusive holder, state unchanged
    acq(3, 0, 2, 0, "R3");
    acq(3, 1, 2, 0, "R4");
    look(3, 0, 1, 0, 0, 0, 0, 0, "R3");
    // R8: commits by non-holders
    commit(3, 2, 3'b111, 3'd0, 48'h5000, 1, 1, "R8");
    look(3, 0, 1, 0, 0, 0, 0, 0, "R8");
    commit(5, 1, 3'b111, 3'd0, 48'h6000, 1, 1, "R8");
    look(5, 0, 0, 0, 0, 0, 0, 0, "R8");
    // R6: valid commit
    commit(3, 1, 3'b110, 3'd0, 48'h12_3456_7000, 7, 0, "R6");
    look(3, 1, 1, 0, 3'd0, 3'b110, 48'h12_3456_7000, 7, "R6");
    // R4: two shared holders on owner page 7
    acq(7, 1, 1, 1, "R4");
    acq(7, 1, 2, 1, "R4");
    look(7, 0, 0, 1, 0, 0, 0, 0, "R4");
    // R5 / R3: exclusive vs shared holders
    acq(7, 0, 3, 0, "R5");
    // R9: shared releases
    rel(7, 1, 1, "R9");
    look(7, 0, 0, 1, 0, 0, 0, 0, "R9");
    rel(7, 1, 2, "R9");
    look(7, 0, 0, 0, 0, 0, 0, 0, "R9");
    acq(7, 0, 3, 1, "R5");
    // R9: release by non-holder ignored, then by holder
    rel(7, 0, 4, "R9");
    look(7, 0, 1, 0, 0, 0, 0, 0, "R9");
    rel(7, 0, 3, "R9");
    look(7, 0, 0, 0, 0, 0, 0, 0, "R9");
    // R7: thread-control forces no permissions
    acq(9, 0, 2, 1, "R7");
    commit(9, 2, 3'b111, 3'd2, 48'hABC000, 7, 0, "R7");
    look(9, 1, 1, 0, 3'd2, 3'b000, 48'hABC000, 7, "R7");
    // R6: shadow-stack type keeps permissions
    commit(9, 2, 3'b110, 3'd3, 48'hABD000, 7, 0, "R6");
    look(9, 1, 1, 0, 3'd3, 3'b110, 48'hABD000, 7, "R6");
    stepStart();
    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

endmodule